// File: doc/BRIEF.md
# Serial Flash Page Erase, Program and Verify Sequencer

This block is the host side of a serial NOR flash connection. A 256-byte page buffer inside the block is loaded through a simple write port. A single start pulse then runs the whole write protocol for one page-aligned 24-bit address. The sequencer erases the 4 KiB sector that holds the page and confirms that the page reads back blank. It then programs the page in one transaction, reads it back and compares it with the buffer. At the end it reports a result code.

Every erase and every program is preceded by a stand-alone write-enable transaction and a status read that must show the write-enable latch set. Every erase and every program is followed by status polling until the flash reports idle. The number of busy polls is bounded by a parameter. The serial pins follow mode 0 with an active-low chip select. Byte payloads and addresses go out most significant bit first.

Top module: `flash_pgm_seq`

## Requirements
- R1: After reset, csN is 1, sclk is 0, busy is 0, done is 0 and pass is 0. Whenever busy is 0, csN is 1.
- R2: The serial link runs in mode 0. sclk idles low while csN is high. mosi changes only while sclk is low, and miso is sampled on the rising sclk edge. Every byte is sent most significant bit first.
- R3: Before the erase and again before the program, opcode 0x06 is sent alone in one transaction. It is followed by a status read (0x05 plus one byte). If bit 1 of that status byte is 0, the run ends with errCode 1, and the pending erase or program opcode is never sent.
- R4: The erase is opcode 0x20 followed by three address bytes, most significant byte first. The address is pageAddr with its low 12 bits cleared.
- R5: After the erase and after the program, status is polled with 0x05 until bit 0 reads 0. If POLL_LIMIT consecutive polls all read bit 0 as 1, the run ends with errCode 2. POLL_LIMIT-1 busy polls still let the run continue.
- R6: After the erase poll, the page is read with 0x03 and the page address. Any byte other than 0xFF ends the run with errCode 3, and failIndex is set to the lowest offending byte offset. No program opcode is sent in that case.
- R7: The program is opcode 0x02, then the three page-address bytes, then exactly 256 buffer bytes starting at offset 0, all within one chip-select assertion.
- R8: The final read (0x03) compares each of the 256 bytes with the buffer. Any difference ends the run with errCode 4, and failIndex is set to the lowest differing offset. A bit that reads 1 where the buffer holds 0 counts as a difference.
- R9: done is a one-cycle pulse at the end of a run, and busy is 0 in that cycle. pass is 1 exactly when errCode is 0. failIndex is 0 when no comparison failed. The results hold until the next accepted start.
- R10: A cycle with bufWrEn high stores bufWrData at offset bufWrAddr. A start pulse while busy is 1 is ignored: the running page address is kept and only one done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bufWrEn | input | 1 | Page buffer write strobe |
| bufWrAddr | input | 8 | Page buffer byte offset |
| bufWrData | input | 8 | Page buffer write data |
| start | input | 1 | Begin a run (accepted when idle) |
| pageAddr | input | 24 | Page-aligned flash byte address |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run finished without error |
| errCode | output | 3 | 0 ok, 1 latch not set, 2 poll limit, 3 not blank, 4 verify mismatch |
| failIndex | output | 8 | First failing byte offset for codes 3 and 4 |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The assertions assume that miso settles while sclk is low and that start is a single-cycle pulse. They also assume that bufWrEn is not used while a run reads the buffer. The bench drives a behavioural flash model that changes miso only on falling sclk and loads the buffer only between runs. Its one overlapping start is a deliberate single pulse during a run, used to show that such a pulse is ignored. Stimulus mixes random page addresses and buffer contents, drawn from a fixed seed, with directed faults. The faults are a refused write-enable, a busy flag held for exactly the poll limit and one poll less, an erase-resistant byte, and cells that will not program to 0.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_SERASE = 8'h20;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;

  typedef enum logic [3:0] {
    PH_WREN_E, PH_CHK_E, PH_ERASE, PH_POLL_E, PH_BLANK,
    PH_WREN_P, PH_CHK_P, PH_PROG, PH_POLL_P, PH_VERIFY
  } phase_e;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0, ERR_WEL = 3'd1, ERR_TIMEOUT = 3'd2,
    ERR_NOTBLANK = 3'd3, ERR_VERIFY = 3'd4
  } err_e;

  // control -> datapath strobes
  typedef struct packed {
    logic csOn;
    logic sendByte;
    logic latchAddr;
    logic clrCmp;
  } strobe_t;
endpackage

// File: rtl/fpgm_datapath.sv
module fpgm_datapath
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 4096,
  parameter int CLK_DIV      = 2,
  localparam int IDX_W       = $clog2(PAGE_BYTES),
  localparam int ADDR_BYTES  = ADDR_W / 8,
  localparam int HDR         = 1 + ADDR_BYTES,
  localparam int XFER_W      = $clog2(HDR + PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  phase_e            phase,
  input  logic [XFER_W-1:0] byteIdx,
  input  logic [ADDR_W-1:0] pageAddr,
  input  logic              bufWrEn,
  input  logic [IDX_W-1:0]  bufWrAddr,
  input  logic [7:0]        bufWrData,
  input  logic              miso,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  output logic              byteDone,
  output logic [1:0]        statBits,
  output logic              cmpBad,
  output logic [IDX_W-1:0]  cmpIdx
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'(SECTOR_BYTES - 1);

  logic [7:0] bufMem [PAGE_BYTES];
  logic [ADDR_W-1:0] addrQ, opAddr, addrShifted;
  logic [IDX_W-1:0] payIdx;
  logic [7:0] txByte, expByte, txSh, rxSh;
  logic [DIV_W-1:0] divCnt;
  logic [2:0] bitCnt;
  logic active, sclkQ, doneQ, csNQ, tick, isRead;

  always_ff @(posedge clk) begin
    if (bufWrEn) bufMem[bufWrAddr] <= bufWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (stb.latchAddr) addrQ <= pageAddr;
  end

  assign payIdx  = IDX_W'(byteIdx - XFER_W'(HDR));
  assign isRead  = (phase == PH_BLANK) || (phase == PH_VERIFY);
  assign opAddr  = (phase == PH_ERASE) ? (addrQ & ~SECT_MASK) : addrQ;
  assign addrShifted = opAddr >> (8 * (ADDR_BYTES - 32'(byteIdx)));
  assign expByte = (phase == PH_BLANK) ? 8'hFF : bufMem[payIdx];

  always_comb begin
    txByte = 8'h00;
    if (byteIdx == '0) begin
      unique case (phase)
        PH_WREN_E, PH_WREN_P: txByte = OP_WREN;
        PH_CHK_E, PH_CHK_P, PH_POLL_E, PH_POLL_P: txByte = OP_RDSR;
        PH_ERASE: txByte = OP_SERASE;
        PH_PROG:  txByte = OP_PROG;
        default:  txByte = OP_READ;
      endcase
    end else if (32'(byteIdx) <= ADDR_BYTES) begin
      txByte = addrShifted[7:0];           // address, most significant byte first
    end else if (phase == PH_PROG) begin
      txByte = bufMem[payIdx];
    end
  end

  // mode 0 byte shifter: launch while low, sample on rise
  assign tick = (divCnt == DIV_W'(CLK_DIV - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; sclkQ <= 1'b0; doneQ <= 1'b0; divCnt <= '0;
      bitCnt <= '0; txSh <= '0; rxSh <= '0; csNQ <= 1'b1;
    end else begin
      doneQ <= 1'b0;
      csNQ  <= !stb.csOn;
      if (stb.sendByte && !active) begin
        active <= 1'b1; txSh <= txByte; bitCnt <= '0; divCnt <= '0; sclkQ <= 1'b0;
      end else if (active) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          if (!sclkQ) begin
            sclkQ <= 1'b1;
            rxSh  <= {rxSh[6:0], miso};
          end else begin
            sclkQ <= 1'b0;
            if (bitCnt == 3'd7) begin
              active <= 1'b0; doneQ <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpBad <= 1'b0; cmpIdx <= '0;
    end else if (stb.clrCmp) begin
      cmpBad <= 1'b0; cmpIdx <= '0;
    end else if (doneQ && isRead && 32'(byteIdx) >= HDR && !cmpBad && rxSh != expByte) begin
      cmpBad <= 1'b1; cmpIdx <= payIdx;
    end
  end

  assign sclk     = sclkQ;
  assign csN      = csNQ;
  assign mosi     = active ? txSh[7] : 1'b0;
  assign byteDone = doneQ;
  assign statBits = rxSh[1:0];
endmodule

// File: rtl/fpgm_control.sv
module fpgm_control
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_LIMIT = 1000,
  parameter int CS_GAP     = 2,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int ADDR_BYTES = ADDR_W / 8,
  localparam int HDR       = 1 + ADDR_BYTES,
  localparam int XFER_W    = $clog2(HDR + PAGE_BYTES + 1),
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1),
  localparam int GAP_W     = $clog2(CS_GAP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              byteDone,
  input  logic [1:0]        statBits,
  input  logic              cmpBad,
  input  logic [IDX_W-1:0]  cmpIdx,
  output strobe_t           stb,
  output phase_e            phase,
  output logic [XFER_W-1:0] byteIdx,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output err_e              errCode,
  output logic [IDX_W-1:0]  failIndex
);
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_GAP} st_e;

  st_e st;
  phase_e phaseQ, nxtPhase;
  err_e errNext;
  logic [XFER_W-1:0] idxQ, lastIdx;
  logic [POLL_W-1:0] pollCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [1:0] statusQ;
  logic finish, pollBusy;

  always_comb begin
    unique case (phaseQ)
      PH_WREN_E, PH_WREN_P: lastIdx = '0;
      PH_CHK_E, PH_CHK_P, PH_POLL_E, PH_POLL_P: lastIdx = XFER_W'(1);
      PH_ERASE: lastIdx = XFER_W'(ADDR_BYTES);
      default:  lastIdx = XFER_W'(HDR + PAGE_BYTES - 1);
    endcase
  end

  always_comb begin
    nxtPhase = phaseQ; finish = 1'b0; errNext = ERR_NONE; pollBusy = 1'b0;
    unique case (phaseQ)
      PH_WREN_E: nxtPhase = PH_CHK_E;
      PH_WREN_P: nxtPhase = PH_CHK_P;
      PH_CHK_E, PH_CHK_P:
        if (statusQ[WEL_BIT]) nxtPhase = (phaseQ == PH_CHK_E) ? PH_ERASE : PH_PROG;
        else begin finish = 1'b1; errNext = ERR_WEL; end
      PH_ERASE: nxtPhase = PH_POLL_E;
      PH_PROG:  nxtPhase = PH_POLL_P;
      PH_POLL_E, PH_POLL_P:
        if (statusQ[BUSY_BIT]) begin
          pollBusy = 1'b1;
          if (pollCnt == POLL_W'(POLL_LIMIT - 1)) begin finish = 1'b1; errNext = ERR_TIMEOUT; end
        end else nxtPhase = (phaseQ == PH_POLL_E) ? PH_BLANK : PH_VERIFY;
      PH_BLANK:
        if (cmpBad) begin finish = 1'b1; errNext = ERR_NOTBLANK; end
        else nxtPhase = PH_WREN_P;
      default: begin finish = 1'b1; errNext = cmpBad ? ERR_VERIFY : ERR_NONE; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; phaseQ <= PH_WREN_E; idxQ <= '0; pollCnt <= '0; gapCnt <= '0;
      statusQ <= '0; done <= 1'b0; pass <= 1'b0; errCode <= ERR_NONE; failIndex <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st <= S_SEND; phaseQ <= PH_WREN_E; idxQ <= '0; pollCnt <= '0;
          pass <= 1'b0; errCode <= ERR_NONE; failIndex <= '0;
        end
        S_SEND: st <= S_WAIT;
        S_WAIT: if (byteDone) begin
          if (idxQ == XFER_W'(1)) statusQ <= statBits;
          if (idxQ == lastIdx) st <= S_GAP;
          else begin idxQ <= idxQ + 1'b1; st <= S_SEND; end
        end
        default: if (gapCnt != GAP_W'(CS_GAP - 1)) gapCnt <= gapCnt + 1'b1;
        else begin
          gapCnt  <= '0;
          idxQ    <= '0;
          pollCnt <= pollBusy ? pollCnt + 1'b1 : '0;
          phaseQ  <= nxtPhase;
          if (finish) begin
            st <= S_IDLE; done <= 1'b1; errCode <= errNext; pass <= (errNext == ERR_NONE);
            failIndex <= (errNext == ERR_NOTBLANK || errNext == ERR_VERIFY) ? cmpIdx : '0;
          end else st <= S_SEND;
        end
      endcase
    end
  end

  assign stb.csOn      = (st == S_SEND) || (st == S_WAIT);
  assign stb.sendByte  = (st == S_SEND);
  assign stb.latchAddr = (st == S_IDLE) && start;
  assign stb.clrCmp    = (st == S_SEND) && (idxQ == '0);
  assign phase   = phaseQ;
  assign byteIdx = idxQ;
  assign busy    = (st != S_IDLE);
endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 4096,
  parameter int CLK_DIV      = 2,
  parameter int POLL_LIMIT   = 1000,
  parameter int CS_GAP       = 2,
  localparam int IDX_W       = $clog2(PAGE_BYTES),
  localparam int XFER_W      = $clog2(1 + ADDR_W / 8 + PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufWrEn,
  input  logic [IDX_W-1:0]  bufWrAddr,
  input  logic [7:0]        bufWrData,
  input  logic              start,
  input  logic [ADDR_W-1:0] pageAddr,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [2:0]        errCode,
  output logic [IDX_W-1:0]  failIndex,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);
  strobe_t stb;
  phase_e phase;
  err_e errQ;
  logic [XFER_W-1:0] byteIdx;
  logic byteDone, cmpBad;
  logic [1:0] statBits;
  logic [IDX_W-1:0] cmpIdx;

  fpgm_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
                  .SECTOR_BYTES(SECTOR_BYTES), .CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .phase(phase), .byteIdx(byteIdx),
    .pageAddr(pageAddr), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .miso(miso), .sclk(sclk), .csN(csN), .mosi(mosi), .byteDone(byteDone),
    .statBits(statBits), .cmpBad(cmpBad), .cmpIdx(cmpIdx));

  fpgm_control #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
                 .POLL_LIMIT(POLL_LIMIT), .CS_GAP(CS_GAP)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .byteDone(byteDone), .statBits(statBits),
    .cmpBad(cmpBad), .cmpIdx(cmpIdx), .stb(stb), .phase(phase), .byteIdx(byteIdx),
    .busy(busy), .done(done), .pass(pass), .errCode(errQ), .failIndex(failIndex));

  assign errCode = errQ;
endmodule

// File: rtl/fpgm_checker.sv
module fpgm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sclk,
  input logic       mosi,
  input logic       busy,
  input logic       done,
  input logic       pass,
  input logic [2:0] errCode
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sclk);   // R2
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN) sclk |-> $stable(mosi)); // R2
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rstN) !busy |-> csN);   // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);     // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);      // R9
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rstN) pass |-> errCode == 3'd0); // R9
  AST_FAIL_CODED: assert property (@(posedge clk) disable iff (!rstN) (done && !pass) |-> errCode != 3'd0); // R9
endmodule

bind flash_pgm_seq fpgm_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
  .busy(busy), .done(done), .pass(pass), .errCode(errCode));

// File: tb/flash_pgm_seq_tb.sv
module flash_pgm_seq_tb;
  localparam int PAGE  = 256;
  localparam int LIMIT = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic bufWrEn = 1'b0, start = 1'b0, miso = 1'b0;
  logic [7:0] bufWrAddr = '0, bufWrData = '0, failIndex;
  logic [23:0] pageAddr = '0;
  logic busy, done, pass, sclk, csN, mosi;
  logic [2:0] errCode;

  always #10 clk = ~clk;

  flash_pgm_seq #(.CLK_DIV(1), .POLL_LIMIT(LIMIT), .CS_GAP(2)) u_dut (
    .clk(clk), .rstN(rstN), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .start(start), .pageAddr(pageAddr), .busy(busy), .done(done), .pass(pass),
    .errCode(errCode), .failIndex(failIndex), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso));

  int nChecks = 0, nFail = 0;
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural flash model ----------------
  logic [7:0] mem [int];
  logic [7:0] cmd = 8'h00, inSh = 8'h00, outSh = 8'h00;
  logic [23:0] madr = '0;
  int nByte = 0, bitN = 0, busyLeft = 0, busyPolls = 2, welGrants = -1;
  int weakA = -1, weakB = -1, stuckAt = -1;
  int eraseCount = 0, progBytes = 0, progCmds = 0, lastErase = -1;
  bit wel = 0, progOk = 0;

  function automatic logic [7:0] rd(input int k);
    return mem.exists(k) ? mem[k] : 8'hFF;
  endfunction

  task automatic onByte(input logic [7:0] b);
    if (nByte == 0) begin
      cmd = b;
      if (b == 8'h05) begin
        outSh = {6'b0, wel, busyLeft > 0};
        if (busyLeft > 0) busyLeft--;
      end
      if (b == 8'h02) progOk = wel;
    end else if (cmd == 8'h05) begin
      outSh = {6'b0, wel, busyLeft > 0};
    end else if (nByte <= 3) begin
      madr = {madr[15:0], b};
      if (cmd == 8'h03 && nByte == 3) begin outSh = rd(int'(madr)); madr++; end
    end else if (cmd == 8'h03) begin
      outSh = rd(int'(madr)); madr++;
    end else if (cmd == 8'h02 && progOk) begin
      int k;
      logic [7:0] nv;
      k = int'({madr[23:8], 8'(madr[7:0] + 8'(nByte - 4))});
      nv = rd(k) & b;
      if (k == weakA || k == weakB) nv[0] = rd(k) & 8'h01 ? 1'b1 : 1'b0;
      mem[k] = nv;
      progBytes++;
    end
  endtask

  always @(negedge csN) begin nByte = 0; bitN = 0; outSh = 8'h00; miso = 1'b0; end
  always @(posedge sclk) if (csN === 1'b0) begin
    inSh = {inSh[6:0], mosi}; bitN++;
    if (bitN == 8) begin bitN = 0; onByte(inSh); nByte++; end
  end
  always @(negedge sclk) if (csN === 1'b0) begin miso = outSh[7]; outSh = {outSh[6:0], 1'b0}; end
  always @(posedge csN) begin
    if (cmd == 8'h06 && nByte == 1 && welGrants != 0) begin
      wel = 1; if (welGrants > 0) welGrants--;
    end else if (cmd == 8'h20 && nByte == 4 && wel) begin
      lastErase = int'(madr) & 32'hFFF000;
      for (int i = 0; i < 4096; i++) if (lastErase + i != stuckAt) mem.delete(lastErase + i);
      eraseCount++; wel = 0; busyLeft = busyPolls;
    end else if (cmd == 8'h02 && nByte >= 4 && progOk) begin
      progCmds++; wel = 0; busyLeft = busyPolls;
    end
    cmd = 8'h00; nByte = 0;
  end

  int donePulses = 0;
  always @(negedge clk) if (done === 1'b1) donePulses++;

  // ---------------- run driver ----------------
  logic [7:0] expBuf [PAGE];
  bit doneSeen;

  task automatic doRun(input logic [23:0] a, input bit midStart);
    mem.delete();
    eraseCount = 0; progBytes = 0; progCmds = 0; lastErase = -1; wel = 0; busyLeft = 0;
    for (int i = 0; i < PAGE; i++) mem[int'(a) + i] = 8'($urandom);
    if (stuckAt >= 0) mem[stuckAt] = 8'h00;
    for (int i = 0; i < PAGE; i++) begin
      @(negedge clk); bufWrEn = 1'b1; bufWrAddr = 8'(i); bufWrData = expBuf[i];
    end
    @(negedge clk); bufWrEn = 1'b0; donePulses = 0;
    pageAddr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    doneSeen = 0;
    for (int c = 0; c < 60000; c++) begin
      @(negedge clk);
      if (midStart && c == 50) begin pageAddr = a ^ 24'h010000; start = 1'b1; end
      else start = 1'b0;
      if (done) begin doneSeen = 1; break; end
    end
    if (!doneSeen) begin
      chk("R9", "run watchdog expired", 0, 1);
      rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    end
    repeat (20) @(negedge clk);
  endtask

  function automatic int pageDiffs(input logic [23:0] a);
    int n = 0;
    for (int i = 0; i < PAGE; i++) if (rd(int'(a) + i) !== expBuf[i]) n++;
    return n;
  endfunction

  task automatic fillRandom();
    for (int i = 0; i < PAGE; i++) expBuf[i] = 8'($urandom);
  endtask

  initial begin
    #(190000 * 20);
    nChecks++; nFail++;
    $display("FAIL global watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [23:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "csN in reset", csN, 1);
    chk("R1", "sclk in reset", sclk, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "pass after reset", pass, 0);

    // full pass with random data, random page, extra start during run
    fillRandom();
    a = {8'($urandom), 8'($urandom), 8'h00};
    doRun(a, 1);
    chk("R9", "pass random", pass, 1);
    chk("R9", "errCode random", errCode, 0);
    chk("R9", "failIndex on pass", failIndex, 0);
    chk("R4", "erase sector address", lastErase, int'(a) & 32'hFFF000);
    chk("R4", "erase count", eraseCount, 1);
    chk("R7", "program byte count", progBytes, 256);
    chk("R7", "program transactions", progCmds, 1);
    chk("R2", "page content matches buffer", pageDiffs(a), 0);
    chk("R10", "single done pulse with ignored start", donePulses, 1);
    chk("R1", "csN idle after run", csN, 1);

    // all zero data, busy exactly one poll below the limit
    for (int i = 0; i < PAGE; i++) expBuf[i] = 8'h00;
    busyPolls = LIMIT - 1;
    a = 24'h03A500;
    doRun(a, 0);
    chk("R5", "limit-1 busy polls pass", pass, 1);
    chk("R5", "limit-1 errCode", errCode, 0);
    chk("R7", "zero page written", pageDiffs(a), 0);

    // busy for the full limit -> timeout after erase
    busyPolls = LIMIT;
    fillRandom();
    doRun(24'h100200, 0);
    chk("R5", "timeout errCode", errCode, 2);
    chk("R5", "timeout no program", progCmds, 0);
    chk("R9", "timeout pass low", pass, 0);
    busyPolls = 2;

    // latch never set
    welGrants = 0;
    doRun(24'h200000, 0);
    chk("R3", "no latch errCode", errCode, 1);
    chk("R3", "no latch no erase", eraseCount, 0);

    // latch set once only: erase happens, program refused
    welGrants = 1;
    doRun(24'h201300, 0);
    chk("R3", "second latch errCode", errCode, 1);
    chk("R3", "second latch erase done", eraseCount, 1);
    chk("R3", "second latch no program", progCmds, 0);
    welGrants = -1;

    // byte that survives the erase
    stuckAt = 24'h055600 + 77;
    doRun(24'h055600, 0);
    chk("R6", "not blank errCode", errCode, 3);
    chk("R6", "not blank failIndex", failIndex, 77);
    chk("R6", "not blank no program", progCmds, 0);
    stuckAt = -1;

    // cells stuck at 1 at offsets 200 and 35
    fillRandom();
    expBuf[200][0] = 1'b0; expBuf[35][0] = 1'b0;
    weakA = 24'h0A0000 + 200; weakB = 24'h0A0000 + 35;
    doRun(24'h0A0000, 0);
    chk("R8", "weak cell errCode", errCode, 4);
    chk("R8", "weak cell first index", failIndex, 35);
    chk("R9", "weak cell pass low", pass, 0);
    weakA = -1; weakB = -1;

    // top page of the address space, alternating pattern
    for (int i = 0; i < PAGE; i++) expBuf[i] = (i % 2 == 0) ? 8'h55 : 8'hAA;
    doRun(24'hFFFF00, 0);
    chk("R4", "top sector address", lastErase, 32'hFFF000);
    chk("R9", "top page pass", pass, 1);
    chk("R10", "top page buffer stored", pageDiffs(24'hFFFF00), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule